// File: doc/BRIEF.md
# Power Supply Supervisor Sequencer

This block is the digital timing and fault-latch controller of a multi-rail supply supervisor. Analog comparators outside the block turn every rail voltage and current sense into a flag, and the block sees only those flags. The flags are a power-good input, one over-voltage, one under-voltage and one over-current flag per rail, and an active-low on/off request. Each input passes through its own filter. A sequencer then decides whether the supply runs and whether power-good is reported.

The sequencer enables the supply when the filtered request turns on. For a start-up window it ignores under-voltage and over-current, but over-voltage is checked at all times. The window is short when power-good is already valid at enable and long when it is not. Any fault that is not blanked latches the supply off and clears power-good. Only a filtered off request releases the latch. A normal off request drops power-good at once and removes the supply after a further delay.

All times are counted on the single clock. Every time is a parameter in cycles, so a testbench can use small values.

Top module: `psu_supervisor`

## Requirements
- R1: In the cycle after a synchronous reset, `fault_off` is 1 (supply disabled) and `pg_out` is 0. All filters return to their idle levels: request off, no faults, power-good invalid.
- R2: `on_req_n` (0 = on, 1 = off) is filtered over `ONOFF_DB_CYC` cycles on both edges. A level that holds for fewer cycles has no effect. A held on request clears `fault_off` `ONOFF_DB_CYC`+1 cycles after the input changes.
- R3: `pg_in` and every bit of `ov_in` and `uv_in` take effect only after they hold a new level for `VOLT_GLITCH_CYC` cycles. A change back before that restarts the filter.
- R4: Every bit of `oc_in` takes effect only after it holds a new level for `CURR_GLITCH_CYC` cycles.
- R5: While the supply is enabled, `pg_out` rises `PG_DELAY_CYC` cycles after the filtered power-good becomes valid. It falls in the same cycle the filtered power-good falls, and losing power-good is not a fault.
- R6: While the supply runs, a filtered fault on any rail (bit i of a flag vector is rail i) sets `fault_off` on the next clock and forces `pg_out` low. For `ov_in` and `uv_in` this is `VOLT_GLITCH_CYC`+1 cycles after the input change; for `oc_in` it is `CURR_GLITCH_CYC`+1 cycles.
- R7: A latched fault holds `fault_off` high while the request stays on, even after all fault flags clear. The latch is released only by a filtered off request, and the supply then stays disabled until a new on request is accepted.
- R8: On a filtered off request while the supply runs, `pg_out` falls in the first cycle after the filter output changes, with `fault_off` still 0. `fault_off` rises `OFF_DELAY_CYC` cycles later.
- R9: After enable, under-voltage and over-current are ignored for `BLANK_SHORT_CYC` cycles if the filtered power-good is valid at enable, and for `BLANK_LONG_CYC` cycles otherwise. A fault already present at enable sets `fault_off` exactly at the end of the window.
- R10: Over-voltage is never blanked. It latches the fault on the next clock in any enabled state, including the start-up window and the off delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| on_req_n | input | 1 | On/off request, 0 requests the supply on |
| pg_in | input | 1 | Power-good comparator flag, 1 = valid |
| ov_in | input | NUM_RAILS | Over-voltage flag per rail |
| uv_in | input | NUM_RAILS | Under-voltage flag per rail |
| oc_in | input | NUM_RAILS | Over-current flag per rail |
| fault_off | output | 1 | 1 disables the supply (fault latched or off) |
| pg_out | output | 1 | Power-good report, 1 = good |

## Verification
Every result has a fixed latency from the input change that causes it:
- Supply enable: request filter length plus one.
- Power-good rise: deglitch length plus the power-good delay.
- Fault latch: the rail's deglitch length plus one.
- Supply removal on off: request filter length plus one plus the off delay.
- Blanked fault: lands exactly at the end of the chosen window.

Inputs change right after a falling edge. The bench then counts falling edges until the output takes its new level and compares the count with the value computed from the parameters. Pulses one cycle shorter than each filter window are swept, and each is followed by a wait longer than the window before the output is sampled.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;

   // sequencer states of the supervisor
   typedef enum logic [2:0] {
      SEQ_OFF    = 3'd0,
      SEQ_BLANK  = 3'd1,
      SEQ_RUN    = 3'd2,
      SEQ_OFFDLY = 3'd3,
      SEQ_FAULT  = 3'd4
   } seq_state_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psu_deglitch.sv
// Level filter: the output follows the input only after the input has
// differed from it for LEN consecutive clocks; any return restarts it.
module psu_deglitch #(
   parameter int unsigned LEN  = 4,
   parameter bit          INIT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic filt
);
   localparam int unsigned CW = $clog2(LEN + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         filt <= INIT;
         cnt  <= '0;
      end else if (raw == filt) begin
         cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
         filt <= raw;
         cnt  <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/psu_countdown.sv
// Loadable down counter that idles at zero.
module psu_countdown #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/psu_seq_ctrl.sv
module psu_seq_ctrl
   import psu_sup_pkg::*;
#(
   parameter int unsigned BLANK_SHORT = 75,
   parameter int unsigned BLANK_LONG  = 300,
   parameter int unsigned OFF_DELAY   = 35,
   parameter int unsigned PG_DELAY    = 300
) (
   input  logic clk,
   input  logic rst,
   input  logic off_req_f,   // filtered request, 1 = off
   input  logic pg_f,
   input  logic ov_any,
   input  logic uv_any,
   input  logic oc_any,
   output logic fault_off,
   output logic pg_out,
   output logic fault_latched
);
   localparam int unsigned TMAX = max_u(max_u(BLANK_SHORT, BLANK_LONG), OFF_DELAY);
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam int unsigned PW   = $clog2(PG_DELAY + 1);
   localparam logic [TW-1:0] T_SHORT = TW'(BLANK_SHORT - 1);
   localparam logic [TW-1:0] T_LONG  = TW'(BLANK_LONG - 1);
   localparam logic [TW-1:0] T_OFF   = TW'(OFF_DELAY - 1);

   seq_state_t    state, state_d;
   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_zero;

   psu_countdown #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_comb begin
      state_d  = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state)
         SEQ_OFF: begin
            if (!off_req_f) begin
               state_d  = SEQ_BLANK;
               tmr_load = 1'b1;
               tmr_val  = pg_f ? T_SHORT : T_LONG;
            end
         end
         SEQ_BLANK: begin
            if (ov_any || (tmr_zero && (uv_any || oc_any))) begin
               state_d = SEQ_FAULT;
            end else if (off_req_f) begin
               state_d  = SEQ_OFFDLY;
               tmr_load = 1'b1;
               tmr_val  = T_OFF;
            end else if (tmr_zero) begin
               state_d = SEQ_RUN;
            end
         end
         SEQ_RUN: begin
            if (ov_any || uv_any || oc_any) begin
               state_d = SEQ_FAULT;
            end else if (off_req_f) begin
               state_d  = SEQ_OFFDLY;
               tmr_load = 1'b1;
               tmr_val  = T_OFF;
            end
         end
         SEQ_OFFDLY: begin
            if (ov_any)        state_d = SEQ_FAULT;
            else if (tmr_zero) state_d = SEQ_OFF;
         end
         SEQ_FAULT: begin
            if (off_req_f) state_d = SEQ_OFF;
         end
         default: state_d = SEQ_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= SEQ_OFF;
      else     state <= state_d;
   end

   // power-good delay: runs while enabled and filtered power-good valid
   logic          run_ok;
   logic [PW-1:0] pg_cnt;
   logic          pg_sat;

   assign run_ok = ((state == SEQ_BLANK) || (state == SEQ_RUN)) && pg_f;

   always_ff @(posedge clk) begin
      if (rst || !run_ok) begin
         pg_cnt <= '0;
         pg_sat <= 1'b0;
      end else if (!pg_sat) begin
         if (pg_cnt == PW'(PG_DELAY - 1)) pg_sat <= 1'b1;
         else                             pg_cnt <= pg_cnt + 1'b1;
      end
   end

   assign pg_out        = pg_sat && run_ok;
   assign fault_off     = (state == SEQ_OFF) || (state == SEQ_FAULT);
   assign fault_latched = (state == SEQ_FAULT);
endmodule

// File: rtl/psu_supervisor.sv
module psu_supervisor #(
   parameter int unsigned NUM_RAILS       = 5,
   parameter int unsigned ONOFF_DB_CYC    = 38000,
   parameter int unsigned VOLT_GLITCH_CYC = 73,
   parameter int unsigned CURR_GLITCH_CYC = 1200,
   parameter int unsigned PG_DELAY_CYC    = 300000,
   parameter int unsigned BLANK_SHORT_CYC = 75000,
   parameter int unsigned BLANK_LONG_CYC  = 300000,
   parameter int unsigned OFF_DELAY_CYC   = 3500
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 on_req_n,
   input  logic                 pg_in,
   input  logic [NUM_RAILS-1:0] ov_in,
   input  logic [NUM_RAILS-1:0] uv_in,
   input  logic [NUM_RAILS-1:0] oc_in,
   output logic                 fault_off,
   output logic                 pg_out
);
   // elaboration-time parameter checks
   if (NUM_RAILS < 1) begin : g_err_rails
      $error("psu_supervisor: NUM_RAILS must be at least 1");
   end
   if (ONOFF_DB_CYC < 1 || VOLT_GLITCH_CYC < 1 || CURR_GLITCH_CYC < 1) begin : g_err_filt
      $error("psu_supervisor: filter lengths must be at least 1");
   end
   if (PG_DELAY_CYC < 1 || OFF_DELAY_CYC < 1) begin : g_err_dly
      $error("psu_supervisor: delays must be at least 1");
   end
   if (BLANK_SHORT_CYC < 1 || BLANK_SHORT_CYC > BLANK_LONG_CYC) begin : g_err_blank
      $error("psu_supervisor: need 1 <= BLANK_SHORT_CYC <= BLANK_LONG_CYC");
   end

   logic                 on_n_f;
   logic                 pg_f;
   logic [NUM_RAILS-1:0] ov_f, uv_f, oc_f;
   logic                 ov_any, uv_any, oc_any;
   logic                 fault_latched;

   psu_deglitch #(.LEN(ONOFF_DB_CYC), .INIT(1'b1)) u_req_db (
      .clk(clk), .rst(rst), .raw(on_req_n), .filt(on_n_f)
   );

   psu_deglitch #(.LEN(VOLT_GLITCH_CYC), .INIT(1'b0)) u_pg_dg (
      .clk(clk), .rst(rst), .raw(pg_in), .filt(pg_f)
   );

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      psu_deglitch #(.LEN(VOLT_GLITCH_CYC), .INIT(1'b0)) u_ov_dg (
         .clk(clk), .rst(rst), .raw(ov_in[i]), .filt(ov_f[i])
      );
      psu_deglitch #(.LEN(VOLT_GLITCH_CYC), .INIT(1'b0)) u_uv_dg (
         .clk(clk), .rst(rst), .raw(uv_in[i]), .filt(uv_f[i])
      );
      psu_deglitch #(.LEN(CURR_GLITCH_CYC), .INIT(1'b0)) u_oc_dg (
         .clk(clk), .rst(rst), .raw(oc_in[i]), .filt(oc_f[i])
      );
   end

   assign ov_any = |ov_f;
   assign uv_any = |uv_f;
   assign oc_any = |oc_f;

   psu_seq_ctrl #(
      .BLANK_SHORT (BLANK_SHORT_CYC),
      .BLANK_LONG  (BLANK_LONG_CYC),
      .OFF_DELAY   (OFF_DELAY_CYC),
      .PG_DELAY    (PG_DELAY_CYC)
   ) u_seq (
      .clk           (clk),
      .rst           (rst),
      .off_req_f     (on_n_f),
      .pg_f          (pg_f),
      .ov_any        (ov_any),
      .uv_any        (uv_any),
      .oc_any        (oc_any),
      .fault_off     (fault_off),
      .pg_out        (pg_out),
      .fault_latched (fault_latched)
   );
endmodule

// File: rtl/psu_supervisor_chk.sv
module psu_supervisor_chk (
   input logic clk,
   input logic rst,
   input logic pg_in,
   input logic fault_off,
   input logic pg_out,
   input logic on_n_f,
   input logic pg_f,
   input logic ov_any,
   input logic fault_latched
);
   // R1: outputs idle right after reset
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (fault_off && !pg_out));

   // R3: filtered power-good only ever takes the level its input had
   a_r3_pg_filter_follows: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $changed(pg_f)) |-> (pg_f == $past(pg_in)));

   // R5: power-good is reported only with valid input and enabled supply
   a_r5_pg_qualified: assert property (@(posedge clk) disable iff (rst)
      pg_out |-> (pg_f && !fault_off));

   // R6: a latched fault never reports power-good
   a_r6_fault_blocks_pg: assert property (@(posedge clk) disable iff (rst)
      fault_latched |-> !pg_out);

   // R7: the latch holds while the request stays on
   a_r7_latch_holds: assert property (@(posedge clk) disable iff (rst)
      (fault_latched && !on_n_f) |=> fault_latched);

   // R8: an accepted off request drops power-good on the next clock
   a_r8_off_drops_pg: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(on_n_f) && pg_out) |=> !pg_out);

   // R10: over-voltage disables an enabled supply on the next clock
   a_r10_ov_unblanked: assert property (@(posedge clk) disable iff (rst)
      (ov_any && !fault_off) |=> fault_off);
endmodule

bind psu_supervisor psu_supervisor_chk u_chk (
   .clk           (clk),
   .rst           (rst),
   .pg_in         (pg_in),
   .fault_off     (fault_off),
   .pg_out        (pg_out),
   .on_n_f        (on_n_f),
   .pg_f          (pg_f),
   .ov_any        (ov_any),
   .fault_latched (fault_latched)
);

// File: tb/test_psu_supervisor.sv
module test_psu_supervisor;
   localparam int N   = 3;
   localparam int DB  = 8;
   localparam int VG  = 3;
   localparam int OCG = 6;
   localparam int PGD = 20;
   localparam int BS  = 10;
   localparam int BL  = 30;
   localparam int OD  = 5;

   logic         clk = 1'b0;
   logic         rst;
   logic         on_req_n;
   logic         pg_in;
   logic [N-1:0] ov_in, uv_in, oc_in;
   logic         fault_off, pg_out;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   psu_supervisor #(
      .NUM_RAILS(N), .ONOFF_DB_CYC(DB), .VOLT_GLITCH_CYC(VG),
      .CURR_GLITCH_CYC(OCG), .PG_DELAY_CYC(PGD), .BLANK_SHORT_CYC(BS),
      .BLANK_LONG_CYC(BL), .OFF_DELAY_CYC(OD)
   ) i_psu_supervisor (
      .clk(clk), .rst(rst), .on_req_n(on_req_n), .pg_in(pg_in),
      .ov_in(ov_in), .uv_in(uv_in), .oc_in(oc_in),
      .fault_off(fault_off), .pg_out(pg_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // count falling edges until the chosen output (0 fault_off, 1 pg_out) equals val
   task automatic wait_out(input bit which, input bit val, input int lim, output int k);
      bit hit = 1'b0;
      k = 0;
      while (!hit && k < lim) begin
         @(negedge clk);
         k++;
         hit = ((which ? pg_out : fault_off) == val);
      end
      if (!hit) k = -1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int k;
      rst = 1'b1; on_req_n = 1'b1; pg_in = 1'b0;
      ov_in = '0; uv_in = '0; oc_in = '0;
      tick(3);
      chk("R1 fault_off in reset", fault_off, 1);
      rst = 1'b0;
      tick(1);
      chk("R1 fault_off after reset", fault_off, 1);
      chk("R1 pg_out after reset", pg_out, 0);

      // R2: request pulses shorter than the debounce window are ignored
      for (int w = 1; w < DB; w++) begin
         on_req_n = 1'b0; tick(w); on_req_n = 1'b1; tick(DB + 3);
         chk("R2 short on pulse ignored", fault_off, 1);
      end

      // R9: long blank when power-good invalid, uv present at enable
      uv_in[0] = 1'b1; tick(VG + 1);
      on_req_n = 1'b0;
      wait_out(0, 0, 100, k); chk("R2 enable latency", k, DB + 1);
      wait_out(0, 1, 100, k); chk("R9 long blank length", k, BL);
      chk("R6 pg low on fault", pg_out, 0);
      on_req_n = 1'b1; tick(DB + 3);
      uv_in = '0; tick(VG + 2);
      chk("R7 stays off after clear", fault_off, 1);

      // R9: short blank when power-good already valid
      pg_in = 1'b1; uv_in[1] = 1'b1; tick(VG + 1);
      on_req_n = 1'b0;
      wait_out(0, 0, 100, k); chk("R2 enable latency pg valid", k, DB + 1);
      wait_out(0, 1, 100, k); chk("R9 short blank length", k, BS);
      on_req_n = 1'b1; uv_in = '0; tick(DB + 4);

      // R5: power-good delay, glitch filtering, loss and return
      on_req_n = 1'b0;
      wait_out(0, 0, 100, k); chk("R2 enable latency", k, DB + 1);
      wait_out(1, 1, 100, k); chk("R5 pg delay from enable", k, PGD);
      for (int w = 1; w < VG; w++) begin
         pg_in = 1'b0; tick(w); pg_in = 1'b1; tick(VG + 1);
         chk("R3 pg glitch ignored", pg_out, 1);
      end
      pg_in = 1'b0;
      wait_out(1, 0, 50, k); chk("R5 pg drop latency", k, VG);
      chk("R5 pg loss is no fault", fault_off, 0);
      pg_in = 1'b1;
      wait_out(1, 1, 100, k); chk("R5 pg return latency", k, VG + PGD);
      for (int w = 1; w < VG; w++) begin
         uv_in[2] = 1'b1; tick(w); uv_in[2] = 1'b0; tick(VG + 2);
         chk("R3 uv glitch ignored", fault_off, 0);
      end
      for (int w = 1; w < OCG; w++) begin
         oc_in[1] = 1'b1; tick(w); oc_in[1] = 1'b0; tick(OCG + 2);
         chk("R4 oc glitch ignored", fault_off, 0);
      end
      for (int w = 1; w < DB; w++) begin
         on_req_n = 1'b1; tick(w); on_req_n = 1'b0; tick(DB + 3);
         chk("R2 short off pulse ignored", pg_out, 1);
      end

      // R8: off sequence
      on_req_n = 1'b1;
      wait_out(1, 0, 100, k); chk("R8 pg drop on off", k, DB + 1);
      chk("R8 supply still on", fault_off, 0);
      wait_out(0, 1, 100, k); chk("R8 off delay", k, OD);
      tick(2);

      // R6 R7 R10: every fault kind on every rail
      for (int kind = 0; kind < 3; kind++) begin
         for (int r = 0; r < N; r++) begin
            on_req_n = 1'b0;
            wait_out(0, 0, 100, k); chk("R2 enable latency", k, DB + 1);
            tick(BL + 2);
            case (kind)
               0: ov_in[r] = 1'b1;
               1: uv_in[r] = 1'b1;
               default: oc_in[r] = 1'b1;
            endcase
            wait_out(0, 1, 100, k);
            chk((kind == 2) ? "R4 R6 oc fault latency" : "R3 R6 volt fault latency",
                k, ((kind == 2) ? OCG : VG) + 1);
            chk("R6 pg forced low", pg_out, 0);
            ov_in = '0; uv_in = '0; oc_in = '0;
            tick(OCG + 3);
            chk("R7 latch holds", fault_off, 1);
            on_req_n = 1'b1; tick(DB + 3);
            chk("R7 off after release", fault_off, 1);
         end
      end

      // R10: over-voltage acts during the blank window
      pg_in = 1'b0; tick(VG + 1);
      on_req_n = 1'b0;
      wait_out(0, 0, 100, k); chk("R2 enable latency", k, DB + 1);
      tick(2);
      ov_in[2] = 1'b1;
      wait_out(0, 1, 100, k); chk("R10 ov in blank", k, VG + 1);
      ov_in = '0; on_req_n = 1'b1; tick(DB + 3);
      chk("R7 off after release", fault_off, 1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule